// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the pending flags of eight peripheral interrupt sources and presents one request with a 16-bit handler address and a 2-bit priority level to the processor. The sources are two timers, a combined serial-port source, a separate serial transmit source, brownout, watchdog/real-time clock, keypad and comparator. Each flag is gated by its own enable bit and by one global enable. The winner is the pending source with the highest programmable level. Among sources at the same level, a fixed rank decides.

The controller tracks the levels whose handlers are in service, so a handler can be preempted by a request of a strictly higher level. An acknowledge records the level of the granted request as in service. A return pulse retires the highest level in service. Once raised, a request and its vector stay frozen until they are acknowledged. A separate combinational wake output lets the wake-capable sources bring the chip out of power-down without any clock-driven logic.

Software programs the controller through a simple write port. A 3-bit select picks one of seven byte registers.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, irq_req, irq_vector and wake are 0, and every enable, level and mode bit is 0, so no flag can raise a request or wake.
- R2: The vectors are 002Bh for brownout, 0053h for watchdog/RTC, 000Bh for timer 0, 003Bh for keypad, 001Bh for timer 1, 0043h for comparator, 006Bh for serial transmit and 0023h for the shared serial source.
- R3: A source requests only when its flag, its enable bit and the global enable are all 1. Select 0 is enable register A: bit 7 global, bit 1 timer 0, bit 3 timer 1, bit 4 serial, bit 5 brownout, bit 6 watchdog/RTC. Select 1 is enable register B: bit 1 keypad, bit 2 comparator, bit 6 serial transmit.
- R4: A source's level is {high bit, low bit}. High bits are at select 2 (group A) and select 4 (group B). Low bits are at select 3 (group A) and select 5 (group B). Bit positions match the enable registers. The highest pending level wins.
- R5: At equal level, the winner is chosen in this order: brownout, watchdog/RTC, timer 0, keypad, timer 1, comparator, serial transmit, shared serial.
- R6: A request is raised only when the winner's level exceeds the highest level in service. If nothing is in service, any winner is raised. irq_ack while irq_req is high marks irq_level as in service. irq_ret retires the highest level in service.
- R7: Between a request rising and its acknowledge, irq_vector and irq_level do not change, even if a higher source becomes pending. irq_req falls on the cycle after the acknowledge.
- R8: wake is 1 when any of brownout, watchdog/RTC, keypad or comparator has its flag and its enable bit set. This holds regardless of the global enable and the in-service state. Timer and serial flags never drive wake.
- R9: With mode bit 1 (select 6) at 0, the transmit flag and the receive flag each request vector 0023h under the serial enable. Vector 006Bh is never requested.
- R10: With mode bit 1 at 1, only the receive flag uses 0023h. The transmit flag requests 006Bh under enable B bit 6.
- R11: With mode bit 0 (select 6) at 1, any of the framing, break or overrun flags also raises the shared serial source. With mode bit 0 at 0, these flags have no effect.
- R12: The watchdog/RTC source is pending when either the watchdog flag or the RTC flag is set.
- R13: When acknowledge and return occur in the same cycle, the old top level is retired and the acknowledged level is marked in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| ser_err_flags | input | 3 | Serial framing, break and overrun flags |
| bod_flag | input | 1 | Brownout flag |
| wdt_flag | input | 1 | Watchdog overflow flag |
| rtc_flag | input | 1 | Real-time clock flag |
| kbd_flag | input | 1 | Keypad flag |
| cmp_flag | input | 1 | Comparator flag |
| irq_ack | input | 1 | Processor accepts the current request |
| irq_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 16 | Handler address of the request |
| irq_level | output | 2 | Priority level of the request |
| wake | output | 1 | Power-down wake indication |

## Verification
An acknowledge that marks a new level as in service can fall in the same cycle as a return that retires the previous top level. The bench provokes this while a low-level timer handler is in service and a high-level brownout request is being granted. It then removes the brownout flag and leaves the timer flag pending. A correct controller raises no timer request until one more return, and raises it right after that return. A second collision sets a higher source pending while a lower request is frozen. The vector must hold until the acknowledge, and the higher source must preempt on the cycle after it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int N_SRC  = 8;
   localparam int LVL_W  = 2;
   localparam int VEC_W  = 16;
   localparam int RANK_W = $clog2(N_SRC);

   // rank order, first wins on a tie
   localparam int RK_BOD  = 0;
   localparam int RK_WDT  = 1;
   localparam int RK_TM0  = 2;
   localparam int RK_KBD  = 3;
   localparam int RK_TM1  = 4;
   localparam int RK_CMP  = 5;
   localparam int RK_STX  = 6;
   localparam int RK_SER  = 7;

   // sources able to leave power-down
   localparam logic [N_SRC-1:0] WAKE_MASK = 8'b0010_1011;

   function automatic logic [VEC_W-1:0] rank_vector(input logic [RANK_W-1:0] rk);
      case (rk)
         3'd0:    return 16'h002B;
         3'd1:    return 16'h0053;
         3'd2:    return 16'h000B;
         3'd3:    return 16'h003B;
         3'd4:    return 16'h001B;
         3'd5:    return 16'h0043;
         3'd6:    return 16'h006B;
         default: return 16'h0023;
      endcase
   endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
   import irq_arb_pkg::*;
(
   input  logic [7:0]                  en_a,
   input  logic [7:0]                  en_b,
   input  logic [7:0]                  hi_a,
   input  logic [7:0]                  lo_a,
   input  logic [7:0]                  hi_b,
   input  logic [7:0]                  lo_b,
   input  logic [7:0]                  mode,
   input  logic                        tmr0_flag,
   input  logic                        tmr1_flag,
   input  logic                        ser_rx_flag,
   input  logic                        ser_tx_flag,
   input  logic [2:0]                  ser_err_flags,
   input  logic                        bod_flag,
   input  logic                        wdt_flag,
   input  logic                        rtc_flag,
   input  logic                        kbd_flag,
   input  logic                        cmp_flag,
   output logic [N_SRC-1:0]            pend,
   output logic [N_SRC-1:0][LVL_W-1:0] lvl,
   output logic                        wake
);
   logic [N_SRC-1:0] raw, ena;
   logic split, err_on, gen;
   logic unused_bits;

   assign split  = mode[1];
   assign err_on = mode[0] & (|ser_err_flags);
   assign gen    = en_a[7];

   always_comb begin
      raw[RK_BOD] = bod_flag;              ena[RK_BOD] = en_a[5]; lvl[RK_BOD] = {hi_a[5], lo_a[5]};
      raw[RK_WDT] = wdt_flag | rtc_flag;   ena[RK_WDT] = en_a[6]; lvl[RK_WDT] = {hi_a[6], lo_a[6]};
      raw[RK_TM0] = tmr0_flag;             ena[RK_TM0] = en_a[1]; lvl[RK_TM0] = {hi_a[1], lo_a[1]};
      raw[RK_KBD] = kbd_flag;              ena[RK_KBD] = en_b[1]; lvl[RK_KBD] = {hi_b[1], lo_b[1]};
      raw[RK_TM1] = tmr1_flag;             ena[RK_TM1] = en_a[3]; lvl[RK_TM1] = {hi_a[3], lo_a[3]};
      raw[RK_CMP] = cmp_flag;              ena[RK_CMP] = en_b[2]; lvl[RK_CMP] = {hi_b[2], lo_b[2]};
      raw[RK_STX] = split & ser_tx_flag;   ena[RK_STX] = en_b[6]; lvl[RK_STX] = {hi_b[6], lo_b[6]};
      raw[RK_SER] = ser_rx_flag | err_on | (~split & ser_tx_flag);
      ena[RK_SER] = en_a[4];               lvl[RK_SER] = {hi_a[4], lo_a[4]};
   end

   assign pend = raw & ena & {N_SRC{gen}};
   assign wake = |(raw & ena & WAKE_MASK);

   assign unused_bits = ^{en_a[0], en_a[2], en_b[0], en_b[5:3], en_b[7],
                          hi_a[0], hi_a[2], hi_a[7], lo_a[0], lo_a[2], lo_a[7],
                          hi_b[0], hi_b[5:3], hi_b[7], lo_b[0], lo_b[5:3], lo_b[7],
                          mode[7:2]};
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N  = 8,
   parameter int LW = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]         pend,
   input  logic [N-1:0][LW-1:0] lvl,
   output logic                 valid,
   output logic [IW-1:0]        idx,
   output logic [LW-1:0]        win_lvl
);
   generate
      if (N == 1) begin : g_single
         assign valid   = pend[0];
         assign idx     = '0;
         assign win_lvl = lvl[0];
      end else begin : g_scan
         always_comb begin
            valid   = 1'b0;
            idx     = '0;
            win_lvl = '0;
            // strict compare keeps the lowest rank among equals
            for (int i = 0; i < N; i++) begin
               if (pend[i] && (!valid || lvl[i] > win_lvl)) begin
                  valid   = 1'b1;
                  idx     = IW'(i);
                  win_lvl = lvl[i];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
   parameter int LW = 2,
   localparam int DEPTH = 1 << LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_lvl,
   input  logic          pop,
   output logic          busy,
   output logic [LW-1:0] top_lvl
);
   logic [DEPTH-1:0] live, live_nx;

   always_comb begin
      top_lvl = '0;
      for (int i = 0; i < DEPTH; i++)
         if (live[i]) top_lvl = LW'(i);
   end
   assign busy = |live;

   always_comb begin
      live_nx = live;
      if (pop && busy) live_nx[top_lvl] = 1'b0;
      if (push)        live_nx[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= '0;
      else        live <= live_nx;
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              tmr0_flag,
   input  logic              tmr1_flag,
   input  logic              ser_rx_flag,
   input  logic              ser_tx_flag,
   input  logic [2:0]        ser_err_flags,
   input  logic              bod_flag,
   input  logic              wdt_flag,
   input  logic              rtc_flag,
   input  logic              kbd_flag,
   input  logic              cmp_flag,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector,
   output logic [LVL_W-1:0]  irq_level,
   output logic              wake
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("irq_arbiter: DATA_W must be at least 8");
      end
      if (SEL_W < 3) begin : g_bad_sel
         $error("irq_arbiter: SEL_W must be at least 3");
      end
   endgenerate

   logic [7:0] en_a, en_b, hi_a, lo_a, hi_b, lo_b, mode;
   logic       gen_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a <= '0; en_b <= '0; hi_a <= '0; lo_a <= '0;
         hi_b <= '0; lo_b <= '0; mode <= '0;
      end else if (reg_we) begin
         case (reg_sel)
            SEL_W'(0): en_a <= reg_wdata[7:0];
            SEL_W'(1): en_b <= reg_wdata[7:0];
            SEL_W'(2): hi_a <= reg_wdata[7:0];
            SEL_W'(3): lo_a <= reg_wdata[7:0];
            SEL_W'(4): hi_b <= reg_wdata[7:0];
            SEL_W'(5): lo_b <= reg_wdata[7:0];
            SEL_W'(6): mode <= reg_wdata[7:0];
            default: ;
         endcase
      end
   end
   assign gen_en = en_a[7];

   logic [N_SRC-1:0]            pend;
   logic [N_SRC-1:0][LVL_W-1:0] lvl;

   irq_src_map u_map (
      .en_a(en_a), .en_b(en_b), .hi_a(hi_a), .lo_a(lo_a),
      .hi_b(hi_b), .lo_b(lo_b), .mode(mode),
      .tmr0_flag(tmr0_flag), .tmr1_flag(tmr1_flag),
      .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
      .ser_err_flags(ser_err_flags), .bod_flag(bod_flag),
      .wdt_flag(wdt_flag), .rtc_flag(rtc_flag),
      .kbd_flag(kbd_flag), .cmp_flag(cmp_flag),
      .pend(pend), .lvl(lvl), .wake(wake)
   );

   logic              cand_ok;
   logic [RANK_W-1:0] cand_idx;
   logic [LVL_W-1:0]  cand_lvl;

   irq_pick #(.N(N_SRC), .LW(LVL_W)) u_pick (
      .pend(pend), .lvl(lvl),
      .valid(cand_ok), .idx(cand_idx), .win_lvl(cand_lvl)
   );

   logic             ns_busy;
   logic [LVL_W-1:0] ns_top;
   logic             req_q;
   logic [VEC_W-1:0] vec_q;
   logic [LVL_W-1:0] lvl_q;
   logic             take;

   irq_nest #(.LW(LVL_W)) u_nest (
      .clk(clk), .rst_n(rst_n),
      .push(req_q & irq_ack), .push_lvl(lvl_q), .pop(irq_ret),
      .busy(ns_busy), .top_lvl(ns_top)
   );

   assign take = cand_ok && (!ns_busy || cand_lvl > ns_top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         lvl_q <= '0;
      end else if (req_q) begin
         if (irq_ack) req_q <= 1'b0;
      end else if (take) begin
         req_q <= 1'b1;
         vec_q <= rank_vector(cand_idx);
         lvl_q <= cand_lvl;
      end
   end

   assign irq_req    = req_q;
   assign irq_vector = vec_q;
   assign irq_level  = lvl_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
   import irq_arb_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic             irq_ack,
   input logic             irq_ret,
   input logic [VEC_W-1:0] irq_vector,
   input logic [LVL_W-1:0] irq_level,
   input logic             wake,
   input logic             ns_busy,
   input logic [LVL_W-1:0] ns_top,
   input logic             gen_en,
   input logic             bod_flag,
   input logic             wdt_flag,
   input logic             rtc_flag,
   input logic             kbd_flag,
   input logic             cmp_flag
);
   p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vector == 16'h002B || irq_vector == 16'h0053 ||
                   irq_vector == 16'h000B || irq_vector == 16'h003B ||
                   irq_vector == 16'h001B || irq_vector == 16'h0043 ||
                   irq_vector == 16'h006B || irq_vector == 16'h0023));

   p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en && !irq_req) |=> !irq_req);

   p_above_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (!$past(ns_busy) || irq_level > $past(ns_top)));

   p_ack_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (ns_busy && ns_top >= $past(irq_level)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector) && $stable(irq_level)));

   p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);

   p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bod_flag || wdt_flag || rtc_flag || kbd_flag || cmp_flag) |-> !wake);

   p_ret_ok_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !ns_busy && !(irq_req && irq_ack)) |=> !ns_busy);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (.*);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [7:0]  reg_wdata = '0;
   logic        tmr0_flag = 0, tmr1_flag = 0, ser_rx_flag = 0, ser_tx_flag = 0;
   logic [2:0]  ser_err_flags = '0;
   logic        bod_flag = 0, wdt_flag = 0, rtc_flag = 0, kbd_flag = 0, cmp_flag = 0;
   logic        irq_ack = 0, irq_ret = 0;
   logic        irq_req;
   logic [15:0] irq_vector;
   logic [1:0]  irq_level;
   logic        wake;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_arbiter uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .tmr0_flag(tmr0_flag), .tmr1_flag(tmr1_flag),
      .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
      .ser_err_flags(ser_err_flags), .bod_flag(bod_flag), .wdt_flag(wdt_flag),
      .rtc_flag(rtc_flag), .kbd_flag(kbd_flag), .cmp_flag(cmp_flag),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
      .irq_vector(irq_vector), .irq_level(irq_level), .wake(wake)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic set_src(input logic [7:0] m);
      bod_flag = m[0]; wdt_flag = m[1]; tmr0_flag = m[2]; kbd_flag = m[3];
      tmr1_flag = m[4]; cmp_flag = m[5]; ser_tx_flag = m[6]; ser_rx_flag = m[7];
      rtc_flag = 1'b0; ser_err_flags = '0;
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic pulse_ret();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
   endtask

   task automatic drain();
      set_src(8'h00);
      if (irq_req) pulse_ack();
      for (int k = 0; k < 4; k++) pulse_ret();
      tick();
   endtask

   task automatic set_levels(input logic [15:0] lp);
      logic [7:0] ha, la, hb, lb;
      ha = '0; la = '0; hb = '0; lb = '0;
      {ha[5], la[5]} = lp[1:0];
      {ha[6], la[6]} = lp[3:2];
      {ha[1], la[1]} = lp[5:4];
      {hb[1], lb[1]} = lp[7:6];
      {ha[3], la[3]} = lp[9:8];
      {hb[2], lb[2]} = lp[11:10];
      {hb[6], lb[6]} = lp[13:12];
      {ha[4], la[4]} = lp[15:14];
      wr(3'd2, ha); wr(3'd3, la); wr(3'd4, hb); wr(3'd5, lb);
   endtask

   function automatic logic [15:0] vec_of(input int r);
      case (r)
         0: return 16'h002B;
         1: return 16'h0053;
         2: return 16'h000B;
         3: return 16'h003B;
         4: return 16'h001B;
         5: return 16'h0043;
         6: return 16'h006B;
         default: return 16'h0023;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      chk("R1 req at reset", {31'd0, irq_req}, 0);
      chk("R1 vector at reset", {16'd0, irq_vector}, 0);
      rst_n = 1'b1;
      tick();
      set_src(8'hFF); rtc_flag = 1'b1;
      tick(); tick();
      chk("R1 no request with cleared registers", {31'd0, irq_req}, 0);
      chk("R1 no wake with cleared registers", {31'd0, wake}, 0);
      set_src(8'h00); tick();

      // enable everything, split serial vectors
      wr(3'd0, 8'hFA); wr(3'd1, 8'h46); wr(3'd6, 8'h02);
      set_levels(16'h0000);

      // R2: each source alone
      for (int r = 0; r < 8; r++) begin
         set_src(8'(1 << r));
         tick();
         chk($sformatf("R2 req rank %0d", r), {31'd0, irq_req}, 1);
         chk($sformatf("R2 vector rank %0d", r), {16'd0, irq_vector}, {16'd0, vec_of(r)});
         drain();
      end

      // R4/R5: level and rank sweep
      for (int p = 0; p < 40; p++) begin
         logic [15:0] lp;
         logic [7:0]  m;
         int best, win;
         for (int r = 0; r < 8; r++) lp[2*r +: 2] = 2'((p * 7 + r * (p + 3)) % 4);
         m = 8'(((p * 53 + 29) % 255) + 1);
         best = -1; win = 0;
         for (int r = 0; r < 8; r++)
            if (m[r] && int'(lp[2*r +: 2]) > best) begin best = int'(lp[2*r +: 2]); win = r; end
         set_levels(lp);
         set_src(m);
         tick();
         chk($sformatf("R4 R5 vector pattern %0d", p), {16'd0, irq_vector}, {16'd0, vec_of(win)});
         chk($sformatf("R4 level pattern %0d", p), {30'd0, irq_level}, 32'(best));
         drain();
      end

      // R5 explicit tie: keypad over transmit and shared serial
      set_levels(16'hFFFF);
      set_src(8'b1100_1000);
      tick();
      chk("R5 tie keypad first", {16'd0, irq_vector}, 32'h003B);
      drain();
      set_levels(16'h0000);

      // R3: global and per-source gating
      wr(3'd0, 8'h7A);
      set_src(8'b0000_0100);
      tick(); tick();
      chk("R3 global off blocks", {31'd0, irq_req}, 0);
      wr(3'd0, 8'hF8);
      tick();
      chk("R3 source enable off blocks", {31'd0, irq_req}, 0);
      wr(3'd0, 8'hFA);
      tick();
      chk("R3 both enables raise", {15'd0, irq_req, irq_vector}, 32'h1000B);
      drain();

      // R8: wake sources
      wr(3'd0, 8'h7A);
      set_src(8'b1101_0100);
      tick();
      chk("R8 timer and serial never wake", {31'd0, wake}, 0);
      set_src(8'b0000_1000);
      tick();
      chk("R8 keypad wakes with global off", {31'd0, wake}, 1);
      wr(3'd1, 8'h44);
      chk("R8 keypad disabled no wake", {31'd0, wake}, 0);
      wr(3'd1, 8'h46);
      wr(3'd0, 8'hFA);
      drain();

      // R12: real-time clock alone
      rtc_flag = 1'b1;
      tick();
      chk("R12 rtc raises watchdog vector", {15'd0, irq_req, irq_vector}, 32'h10053);
      chk("R12 rtc wakes", {31'd0, wake}, 1);
      drain();

      // R9: shared serial mode
      wr(3'd6, 8'h00);
      set_src(8'b0100_0000);
      tick();
      chk("R9 tx uses shared vector", {15'd0, irq_req, irq_vector}, 32'h10023);
      drain();
      // R10: split mode
      wr(3'd6, 8'h02);
      set_src(8'b0100_0000);
      tick();
      chk("R10 tx uses own vector", {15'd0, irq_req, irq_vector}, 32'h1006B);
      drain();
      set_src(8'b1000_0000);
      tick();
      chk("R10 rx uses shared vector", {15'd0, irq_req, irq_vector}, 32'h10023);
      drain();
      // R11: error flags
      ser_err_flags = 3'b010;
      tick(); tick();
      chk("R11 errors ignored when off", {31'd0, irq_req}, 0);
      wr(3'd6, 8'h03);
      tick();
      chk("R11 errors raise shared vector", {15'd0, irq_req, irq_vector}, 32'h10023);
      drain();
      wr(3'd6, 8'h02);

      // R6/R7/R13 nesting: timer 0 and brownout at level 1
      wr(3'd3, 8'h22);
      set_src(8'b0000_0100);
      tick();
      chk("R6 timer request level 1", {13'd0, irq_level, irq_req, irq_vector}, 32'h3000B);
      pulse_ack();
      bod_flag = 1'b1;
      tick(); tick();
      chk("R6 equal level does not preempt", {31'd0, irq_req}, 0);
      wr(3'd2, 8'h20);
      tick();
      chk("R6 higher level preempts", {13'd0, irq_level, irq_req, irq_vector}, 32'h7002B);
      pulse_ack();
      pulse_ret();
      tick();
      chk("R6 return reopens level 3", {15'd0, irq_req, irq_vector}, 32'h1002B);
      irq_ack = 1'b1; irq_ret = 1'b1;
      tick();
      irq_ack = 1'b0; irq_ret = 1'b0; bod_flag = 1'b0;
      tick(); tick();
      chk("R13 level 3 in service blocks timer", {31'd0, irq_req}, 0);
      pulse_ret();
      tick();
      chk("R13 timer level retired with ack", {15'd0, irq_req, irq_vector}, 32'h1000B);
      bod_flag = 1'b1;
      tick(); tick();
      chk("R7 vector held until ack", {13'd0, irq_level, irq_req, irq_vector}, 32'h3000B);
      pulse_ack();
      chk("R7 request drops after ack", {31'd0, irq_req}, 0);
      tick();
      chk("R7 preempt after ack", {15'd0, irq_req, irq_vector}, 32'h1002B);
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule